// File: doc/BRIEF.md
# Multi-Host Shared Memory Bus Arbiter

This block lets several host ports share one small byte-wide memory. Every host sees five independent valid/ready channels: write request, write data, write response, read request and read data. Two round-robin arbiters run side by side, one for write requests and one for read requests. A write and a read from different hosts can therefore be in progress in the same cycles.

When a host wins a request channel, the block records the host index as the transaction ID. On the write side, only that host's data beats are taken until the beat marked last has been accepted. The write response and the read data are returned only to the host whose index matches the stored ID.

Behind the arbiters, a memory controller turns accepted beats into write-enable, address and data, and returns read data after one registered cycle. Write and read bursts step through consecutive byte addresses. An address is reduced modulo the memory depth, so a burst that runs past the top wraps to location 0.

Top module: `shbus_top`

## Requirements
- R1: After a synchronous active-low reset, no write response, no read data and no write-data ready is asserted, and no request ready is raised while no request valid is high. Both arbitration pointers start at host 0.
- R2: Write-request arbitration is round-robin. The winner is the first requesting host at or after the pointer, counting upward with wrap. After each accepted write request the pointer moves to the winner's index plus one, modulo the host count.
- R3: Read-request arbitration follows the same rule as R2 with its own pointer, which write grants do not move.
- R4: On each request channel, at most one ready is high in a cycle, and only to a host whose valid is high.
- R5: After a write request is accepted, only that host's write-data ready can be high, and no write request is accepted, until a beat with last set has been accepted. Beats offered by other hosts in that time are not written.
- R6: Beat k of a write burst is stored at (request address + k) modulo the depth. Cycles where the owner's data valid is low write nothing and do not advance the address.
- R7: In the cycle after the last write beat is accepted, write-response valid rises for the owning host only, with the done bit at 1. It stays high until that host's response ready is sampled high. No write request is accepted meanwhile.
- R8: In the cycle after a read request carrying length field L is accepted, read-data valid rises for the requester. The request delivers L+1 beats holding the bytes at (address + k) modulo the depth, with last set on beat L only.
- R9: While read-data valid is high and ready is low, the valid, data and last outputs hold their values.
- R10: A read request can be granted and answered while the write path is locked to another host awaiting data.
- R11: Across all hosts, at most one write-response valid and at most one read-data valid are high at a time, each for the host that issued the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wreq_valid | input | N_HOSTS | Write request valid per host |
| wreq_ready | output | N_HOSTS | Write request accepted per host |
| wreq_addr | input | N_HOSTS x ADDR_W | Write start address per host |
| wdat_valid | input | N_HOSTS | Write data valid per host |
| wdat_ready | output | N_HOSTS | Write data accepted per host |
| wdat_data | input | N_HOSTS x DATA_W | Write data byte per host |
| wdat_last | input | N_HOSTS | Marks final write beat |
| wrsp_valid | output | N_HOSTS | Write response valid per host |
| wrsp_ready | input | N_HOSTS | Write response taken per host |
| wrsp_done | output | N_HOSTS | Completion bit, 1 when response valid |
| rreq_valid | input | N_HOSTS | Read request valid per host |
| rreq_ready | output | N_HOSTS | Read request accepted per host |
| rreq_addr | input | N_HOSTS x ADDR_W | Read start address per host |
| rreq_len | input | N_HOSTS x LEN_W | Read beats minus one |
| rdat_valid | output | N_HOSTS | Read data valid per host |
| rdat_ready | input | N_HOSTS | Read data taken per host |
| rdat_data | output | N_HOSTS x DATA_W | Read data byte |
| rdat_last | output | N_HOSTS | Marks final read beat |

## Verification
The bench builds the block with three hosts, a 64-byte memory, 32-bit addresses and a 2-bit read length field. Three hosts is a count that is not a power of two, so the pointer wraps from host 2 back to host 0 rather than overflowing a field. The bench sweeps every non-empty set of simultaneous requesters on both request channels and checks each grant against an arithmetic model of the rotating pointer. The small depth puts a burst that crosses the top address within reach. A read issued while another host holds the write lock shows that the two paths are independent.

// File: rtl/shbus_pkg.sv
// Shared types for the multi-host shared bus arbiter.
// Assumes: used by the write path and read path state machines only.
package shbus_pkg;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_DATA = 2'd1,
        WR_RESP = 2'd2
    } wr_state_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_BEAT = 1'b1
    } rd_state_e;

endpackage

// File: rtl/shbus_rr_pick.sv
// Round-robin pick: returns the first requesting index at or after ptr,
// counting upward with wrap.
// Assumes: ptr < N_HOSTS. Purely combinational.
module shbus_rr_pick #(
    parameter int N_HOSTS = 3,
    localparam int HID_W = (N_HOSTS > 1) ? $clog2(N_HOSTS) : 1
) (
    input  logic [N_HOSTS-1:0] req,
    input  logic [HID_W-1:0]   ptr,
    output logic               any,
    output logic [HID_W-1:0]   pick
);

    // Scan from the farthest offset down so the nearest requester wins.
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = N_HOSTS - 1; k >= 0; k--) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= N_HOSTS) idx = idx - N_HOSTS;
            if (req[HID_W'(idx)]) begin
                any  = 1'b1;
                pick = HID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/shbus_ram.sv
// Byte memory behind the device port: one write port, one registered read
// port (one-cycle latency, output held until the next read enable).
// Assumes: addresses are reduced modulo DEPTH; a read and write of the same
// location in one cycle returns the old byte.
module shbus_ram #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  widx;
    logic [IDX_W-1:0]  ridx;

    // Map full bus addresses onto storage locations.
    always_comb begin
        widx = IDX_W'(waddr % ADDR_W'(DEPTH));
        ridx = IDX_W'(raddr % ADDR_W'(DEPTH));
    end

    // Storage write port.
    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[ridx];
    end

endmodule

// File: rtl/shbus_wr_path.sv
// Write side: round-robin grant of write requests, lock to the winner until
// its last data beat, then a held write response to the same host.
// Assumes: the owner index doubles as the transaction ID for routing.
module shbus_wr_path
    import shbus_pkg::*;
#(
    parameter int N_HOSTS = 3,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 8,
    localparam int HID_W  = (N_HOSTS > 1) ? $clog2(N_HOSTS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_HOSTS-1:0]             wreq_valid,
    output logic [N_HOSTS-1:0]             wreq_ready,
    input  logic [N_HOSTS-1:0][ADDR_W-1:0] wreq_addr,
    input  logic [N_HOSTS-1:0]             wdat_valid,
    output logic [N_HOSTS-1:0]             wdat_ready,
    input  logic [N_HOSTS-1:0][DATA_W-1:0] wdat_data,
    input  logic [N_HOSTS-1:0]             wdat_last,
    output logic [N_HOSTS-1:0]             wrsp_valid,
    input  logic [N_HOSTS-1:0]             wrsp_ready,
    output logic                           mem_we,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic [DATA_W-1:0]              mem_wdata
);

    wr_state_e         st;
    logic [HID_W-1:0]  owner;
    logic [HID_W-1:0]  ptr;
    logic [ADDR_W-1:0] addr_q;
    logic              any;
    logic [HID_W-1:0]  pick;
    logic              beat_ok;

    shbus_rr_pick #(.N_HOSTS(N_HOSTS)) u_pick (
        .req  (wreq_valid),
        .ptr  (ptr),
        .any  (any),
        .pick (pick)
    );

    // Steer handshakes to the winner or the current owner by state.
    always_comb begin
        wreq_ready = '0;
        wdat_ready = '0;
        wrsp_valid = '0;
        case (st)
            WR_IDLE: if (any) wreq_ready[pick] = 1'b1;
            WR_DATA: wdat_ready[owner] = 1'b1;
            WR_RESP: wrsp_valid[owner] = 1'b1;
            default: ;
        endcase
    end

    // Memory write strobe from the owner's accepted beat.
    always_comb begin
        beat_ok   = (st == WR_DATA) && wdat_valid[owner];
        mem_we    = beat_ok;
        mem_addr  = addr_q;
        mem_wdata = wdat_data[owner];
    end

    // Grant, lock, burst address and response sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= WR_IDLE;
            owner  <= '0;
            ptr    <= '0;
            addr_q <= '0;
        end else begin
            case (st)
                WR_IDLE: if (any) begin
                    owner  <= pick;
                    addr_q <= wreq_addr[pick];
                    ptr    <= (pick == HID_W'(N_HOSTS - 1)) ? '0 : pick + 1'b1;
                    st     <= WR_DATA;
                end
                WR_DATA: if (beat_ok) begin
                    addr_q <= addr_q + 1'b1;
                    if (wdat_last[owner]) st <= WR_RESP;
                end
                WR_RESP: if (wrsp_ready[owner]) st <= WR_IDLE;
                default: st <= WR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/shbus_rd_path.sv
// Read side: round-robin grant of read requests, then length+1 beats from
// consecutive addresses returned to the requesting host.
// Assumes: memory read data arrives one cycle after mem_re and is held.
module shbus_rd_path
    import shbus_pkg::*;
#(
    parameter int N_HOSTS = 3,
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 2,
    localparam int HID_W  = (N_HOSTS > 1) ? $clog2(N_HOSTS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_HOSTS-1:0]             rreq_valid,
    output logic [N_HOSTS-1:0]             rreq_ready,
    input  logic [N_HOSTS-1:0][ADDR_W-1:0] rreq_addr,
    input  logic [N_HOSTS-1:0][LEN_W-1:0]  rreq_len,
    output logic [N_HOSTS-1:0]             rdat_valid,
    input  logic [N_HOSTS-1:0]             rdat_ready,
    output logic [N_HOSTS-1:0]             rdat_last,
    output logic                           mem_re,
    output logic [ADDR_W-1:0]              mem_raddr
);

    rd_state_e         st;
    logic [HID_W-1:0]  owner;
    logic [HID_W-1:0]  ptr;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  cnt;
    logic              any;
    logic [HID_W-1:0]  pick;
    logic              take;

    shbus_rr_pick #(.N_HOSTS(N_HOSTS)) u_pick (
        .req  (rreq_valid),
        .ptr  (ptr),
        .any  (any),
        .pick (pick)
    );

    // Request grant and beat routing by owner ID.
    always_comb begin
        rreq_ready = '0;
        rdat_valid = '0;
        rdat_last  = '0;
        if (st == RD_IDLE) begin
            if (any) rreq_ready[pick] = 1'b1;
        end else begin
            rdat_valid[owner] = 1'b1;
            rdat_last[owner]  = (cnt == '0);
        end
    end

    // Memory read issue: on grant, and on each taken beat that is not final.
    always_comb begin
        take      = (st == RD_BEAT) && rdat_ready[owner];
        mem_re    = ((st == RD_IDLE) && any) || (take && (cnt != '0));
        mem_raddr = (st == RD_IDLE) ? rreq_addr[pick] : addr_q;
    end

    // Grant, beat counting and next-address tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= RD_IDLE;
            owner  <= '0;
            ptr    <= '0;
            addr_q <= '0;
            cnt    <= '0;
        end else begin
            case (st)
                RD_IDLE: if (any) begin
                    owner  <= pick;
                    addr_q <= rreq_addr[pick] + 1'b1;
                    cnt    <= rreq_len[pick];
                    ptr    <= (pick == HID_W'(N_HOSTS - 1)) ? '0 : pick + 1'b1;
                    st     <= RD_BEAT;
                end
                RD_BEAT: if (take) begin
                    if (cnt == '0) begin
                        st <= RD_IDLE;
                    end else begin
                        cnt    <= cnt - 1'b1;
                        addr_q <= addr_q + 1'b1;
                    end
                end
                default: st <= RD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/shbus_top.sv
// Multi-host shared bus arbiter with a byte memory as the single device.
// Independent write and read arbitration; responses routed by host ID.
// Assumes: N_HOSTS >= 2; synchronous active-low reset.
module shbus_top #(
    parameter int N_HOSTS = 3,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 8,
    parameter int LEN_W   = 2,
    parameter int DEPTH   = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_HOSTS-1:0]             wreq_valid,
    output logic [N_HOSTS-1:0]             wreq_ready,
    input  logic [N_HOSTS-1:0][ADDR_W-1:0] wreq_addr,
    input  logic [N_HOSTS-1:0]             wdat_valid,
    output logic [N_HOSTS-1:0]             wdat_ready,
    input  logic [N_HOSTS-1:0][DATA_W-1:0] wdat_data,
    input  logic [N_HOSTS-1:0]             wdat_last,
    output logic [N_HOSTS-1:0]             wrsp_valid,
    input  logic [N_HOSTS-1:0]             wrsp_ready,
    output logic [N_HOSTS-1:0]             wrsp_done,
    input  logic [N_HOSTS-1:0]             rreq_valid,
    output logic [N_HOSTS-1:0]             rreq_ready,
    input  logic [N_HOSTS-1:0][ADDR_W-1:0] rreq_addr,
    input  logic [N_HOSTS-1:0][LEN_W-1:0]  rreq_len,
    output logic [N_HOSTS-1:0]             rdat_valid,
    input  logic [N_HOSTS-1:0]             rdat_ready,
    output logic [N_HOSTS-1:0][DATA_W-1:0] rdat_data,
    output logic [N_HOSTS-1:0]             rdat_last
);

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_re;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;

    shbus_wr_path #(
        .N_HOSTS(N_HOSTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wreq_valid (wreq_valid),
        .wreq_ready (wreq_ready),
        .wreq_addr  (wreq_addr),
        .wdat_valid (wdat_valid),
        .wdat_ready (wdat_ready),
        .wdat_data  (wdat_data),
        .wdat_last  (wdat_last),
        .wrsp_valid (wrsp_valid),
        .wrsp_ready (wrsp_ready),
        .mem_we     (mem_we),
        .mem_addr   (mem_waddr),
        .mem_wdata  (mem_wdata)
    );

    shbus_rd_path #(
        .N_HOSTS(N_HOSTS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rreq_valid (rreq_valid),
        .rreq_ready (rreq_ready),
        .rreq_addr  (rreq_addr),
        .rreq_len   (rreq_len),
        .rdat_valid (rdat_valid),
        .rdat_ready (rdat_ready),
        .rdat_last  (rdat_last),
        .mem_re     (mem_re),
        .mem_raddr  (mem_raddr)
    );

    shbus_ram #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    // Fan the shared read byte and the completion bit out to every host.
    for (genvar h = 0; h < N_HOSTS; h++) begin : g_host_out
        assign rdat_data[h] = mem_rdata;
        assign wrsp_done[h] = wrsp_valid[h];
    end

endmodule

// File: rtl/shbus_top_chk.sv
// Protocol checker for shbus_top, attached by bind below.
// Assumes: port names match the top module.
module shbus_top_chk #(
    parameter int N_HOSTS = 3,
    parameter int DATA_W  = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [N_HOSTS-1:0]             wreq_valid,
    input logic [N_HOSTS-1:0]             wreq_ready,
    input logic [N_HOSTS-1:0]             wdat_valid,
    input logic [N_HOSTS-1:0]             wdat_ready,
    input logic [N_HOSTS-1:0]             wdat_last,
    input logic [N_HOSTS-1:0]             wrsp_valid,
    input logic [N_HOSTS-1:0]             wrsp_ready,
    input logic [N_HOSTS-1:0]             rreq_valid,
    input logic [N_HOSTS-1:0]             rreq_ready,
    input logic [N_HOSTS-1:0]             rdat_valid,
    input logic [N_HOSTS-1:0]             rdat_ready,
    input logic [N_HOSTS-1:0][DATA_W-1:0] rdat_data,
    input logic [N_HOSTS-1:0]             rdat_last
);

    p_wgrant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wreq_ready) && ((wreq_ready & ~wreq_valid) == '0));

    p_rgrant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rreq_ready) && ((rreq_ready & ~rreq_valid) == '0));

    p_lock_no_wreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wdat_ready != '0) |-> ((wreq_ready == '0) && $onehot0(wdat_ready)));

    p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((wdat_ready & wdat_valid & ~wdat_last) != '0) |=> (wdat_ready == $past(wdat_ready)));

    p_wrsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((wrsp_valid & ~wrsp_ready) != '0) |=> (wrsp_valid == $past(wrsp_valid)));

    p_rdat_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rreq_valid & rreq_ready) != '0) |=> (rdat_valid == $past(rreq_ready)));

    p_rdat_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdat_valid & ~rdat_ready) != '0) |=>
            ($stable(rdat_valid) && $stable(rdat_data) && $stable(rdat_last)));

    p_resp_route_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wrsp_valid) && $onehot0(rdat_valid));

endmodule

bind shbus_top shbus_top_chk #(
    .N_HOSTS(N_HOSTS), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/shbus_top_tb_top.sv
module shbus_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NH    = 3;
    localparam int AW    = 32;
    localparam int DW    = 8;
    localparam int LW    = 2;
    localparam int DEPTH = 64;
    localparam int HW    = 2;
    localparam int MW    = $clog2(DEPTH);

    logic                   clk;
    logic                   rst_n;
    logic [NH-1:0]          wreq_valid, wreq_ready;
    logic [NH-1:0][AW-1:0]  wreq_addr;
    logic [NH-1:0]          wdat_valid, wdat_ready, wdat_last;
    logic [NH-1:0][DW-1:0]  wdat_data;
    logic [NH-1:0]          wrsp_valid, wrsp_ready, wrsp_done;
    logic [NH-1:0]          rreq_valid, rreq_ready;
    logic [NH-1:0][AW-1:0]  rreq_addr;
    logic [NH-1:0][LW-1:0]  rreq_len;
    logic [NH-1:0]          rdat_valid, rdat_ready, rdat_last;
    logic [NH-1:0][DW-1:0]  rdat_data;

    shbus_top #(
        .N_HOSTS(NH), .ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .DEPTH(DEPTH)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wreq_valid(wreq_valid), .wreq_ready(wreq_ready), .wreq_addr(wreq_addr),
        .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_data(wdat_data),
        .wdat_last(wdat_last),
        .wrsp_valid(wrsp_valid), .wrsp_ready(wrsp_ready), .wrsp_done(wrsp_done),
        .rreq_valid(rreq_valid), .rreq_ready(rreq_ready), .rreq_addr(rreq_addr),
        .rreq_len(rreq_len),
        .rdat_valid(rdat_valid), .rdat_ready(rdat_ready), .rdat_data(rdat_data),
        .rdat_last(rdat_last)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int wptr_m = 0;
    int rptr_m = 0;
    logic [DW-1:0] shadow [DEPTH];

    function automatic logic [HW-1:0] hx(input int g);
        return HW'(g);
    endfunction

    function automatic logic [MW-1:0] mx(input int a);
        return MW'(a % DEPTH);
    endfunction

    function automatic logic [NH-1:0] oh(input int g);
        return NH'(1) << g;
    endfunction

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'((a * 37 + salt * 11 + 5) % 256);
    endfunction

    // Expected round-robin winner from the requirement's rule.
    function automatic int rr_model(input logic [NH-1:0] m, input int p);
        for (int k = 0; k < NH; k++) begin
            if (m[hx((p + k) % NH)]) return (p + k) % NH;
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Every host in mask requests a one-beat write at once; grants follow R2.
    task automatic wr_round(input int mask, input int salt);
        logic [NH-1:0] pending;
        int g;
        int a;
        @(negedge clk);
        pending = NH'(mask);
        for (int h = 0; h < NH; h++) wreq_addr[hx(h)] = AW'(mask * 8 + h);
        wreq_valid = pending;
        while (pending != '0) begin
            #1;
            g = rr_model(pending, wptr_m);
            a = mask * 8 + g;
            chk(wreq_ready == oh(g), "R2", "write grant", int'(wreq_ready), int'(oh(g)));
            @(posedge clk);
            @(negedge clk);
            pending = pending & ~oh(g);
            wreq_valid = pending;
            wptr_m = (g + 1) % NH;
            for (int h = 0; h < NH; h++) begin
                wdat_valid[hx(h)] = 1'b1;
                wdat_last[hx(h)]  = 1'b1;
                wdat_data[hx(h)]  = 8'hEE;
            end
            wdat_data[hx(g)] = pat(a, salt);
            #1;
            chk(wdat_ready == oh(g), "R5", "data ready owner only", int'(wdat_ready), int'(oh(g)));
            chk(wreq_ready == '0, "R5", "no grant while locked", int'(wreq_ready), 0);
            @(posedge clk);
            @(negedge clk);
            wdat_valid = '0;
            wdat_last  = '0;
            shadow[mx(a)] = pat(a, salt);
            #1;
            chk(wrsp_valid == oh(g), "R7", "response to owner", int'(wrsp_valid), int'(oh(g)));
            chk(wrsp_done[hx(g)] == 1'b1, "R7", "done bit", int'(wrsp_done[hx(g)]), 1);
            chk(wreq_ready == '0, "R7", "no grant while response pending", int'(wreq_ready), 0);
            @(negedge clk);
            #1;
            chk(wrsp_valid == oh(g), "R7", "response held", int'(wrsp_valid), int'(oh(g)));
            wrsp_ready[hx(g)] = 1'b1;
            @(posedge clk);
            @(negedge clk);
            wrsp_ready = '0;
        end
    endtask

    // Every host in mask requests a one-beat read at once; grants follow R3.
    task automatic rd_round(input int mask);
        logic [NH-1:0] pending;
        int g;
        int a;
        @(negedge clk);
        pending = NH'(mask);
        rreq_len = '0;
        for (int h = 0; h < NH; h++) rreq_addr[hx(h)] = AW'(mask * 8 + h);
        rreq_valid = pending;
        while (pending != '0) begin
            #1;
            g = rr_model(pending, rptr_m);
            a = mask * 8 + g;
            chk(rreq_ready == oh(g), "R3", "read grant", int'(rreq_ready), int'(oh(g)));
            @(posedge clk);
            @(negedge clk);
            pending = pending & ~oh(g);
            rreq_valid = pending;
            rptr_m = (g + 1) % NH;
            #1;
            chk(rdat_valid == oh(g), "R11", "read routed", int'(rdat_valid), int'(oh(g)));
            chk(rdat_data[hx(g)] == shadow[mx(a)], "R8", "read byte",
                int'(rdat_data[hx(g)]), int'(shadow[mx(a)]));
            chk(rdat_last[hx(g)] == 1'b1, "R8", "single beat last", int'(rdat_last[hx(g)]), 1);
            rdat_ready[hx(g)] = 1'b1;
            @(posedge clk);
            @(negedge clk);
            rdat_ready = '0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        wreq_valid = '0; wreq_addr = '0;
        wdat_valid = '0; wdat_data = '0; wdat_last = '0;
        wrsp_ready = '0;
        rreq_valid = '0; rreq_addr = '0; rreq_len = '0;
        rdat_ready = '0;
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle outputs after reset
        chk(wrsp_valid == '0, "R1", "write response idle", int'(wrsp_valid), 0);
        chk(rdat_valid == '0, "R1", "read data idle", int'(rdat_valid), 0);
        chk(wdat_ready == '0, "R1", "data ready idle", int'(wdat_ready), 0);
        chk(wreq_ready == '0, "R1", "no write grant", int'(wreq_ready), 0);
        chk(rreq_ready == '0, "R1", "no read grant", int'(rreq_ready), 0);

        // R2, R4, R5, R7: all requester sets on the write channel
        for (int m = 1; m < (1 << NH); m++) wr_round(m, m);
        // R3, R8, R11: all requester sets on the read channel
        for (int m = 1; m < (1 << NH); m++) rd_round(m);

        // R6: four-beat write from host 1 wrapping past the top, with a gap
        @(negedge clk);
        wreq_addr[1] = AW'(62);
        wreq_valid[1] = 1'b1;
        #1;
        chk(wreq_ready == 3'b010, "R2", "burst write grant", int'(wreq_ready), 2);
        @(posedge clk);
        @(negedge clk);
        wreq_valid = '0;
        wptr_m = 2;
        for (int b = 0; b < 4; b++) begin
            if (b == 2) begin
                wdat_valid[1] = 1'b1;
                wdat_data[1] = 8'h99;
                wdat_valid[1] = 1'b0;
                @(posedge clk);
                @(negedge clk);
            end
            wdat_valid[1] = 1'b1;
            wdat_data[1]  = pat(62 + b, 3);
            wdat_last[1]  = (b == 3);
            @(posedge clk);
            @(negedge clk);
            shadow[mx(62 + b)] = pat(62 + b, 3);
        end
        wdat_valid = '0;
        wdat_last  = '0;
        #1;
        chk(wrsp_valid == 3'b010, "R7", "burst response", int'(wrsp_valid), 2);
        wrsp_ready[1] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wrsp_ready = '0;

        // R8, R9: four-beat read from host 2 over the same wrapped range
        rreq_addr[2] = AW'(62);
        rreq_len[2]  = LW'(3);
        rreq_valid[2] = 1'b1;
        #1;
        chk(rreq_ready == 3'b100, "R3", "burst read grant", int'(rreq_ready), 4);
        @(posedge clk);
        @(negedge clk);
        rreq_valid = '0;
        rptr_m = 0;
        for (int b = 0; b < 4; b++) begin
            #1;
            chk(rdat_valid == 3'b100, "R8", "burst beat valid", int'(rdat_valid), 4);
            chk(rdat_data[2] == shadow[mx(62 + b)], "R6", "burst byte at wrapped address",
                int'(rdat_data[2]), int'(shadow[mx(62 + b)]));
            chk(rdat_last[2] == (b == 3), "R8", "last on final beat",
                int'(rdat_last[2]), int'(b == 3));
            if (b == 1) begin
                repeat (2) @(negedge clk);
                #1;
                chk(rdat_data[2] == shadow[mx(62 + b)], "R9", "held byte under backpressure",
                    int'(rdat_data[2]), int'(shadow[mx(62 + b)]));
                chk(rdat_valid == 3'b100, "R9", "held valid", int'(rdat_valid), 4);
            end
            rdat_ready[2] = 1'b1;
            @(posedge clk);
            @(negedge clk);
            rdat_ready = '0;
        end
        #1;
        chk(rdat_valid == '0, "R8", "burst ends after L+1 beats", int'(rdat_valid), 0);

        // R10: read served while host 0 holds the write lock
        @(negedge clk);
        wreq_addr[0] = AW'(20);
        wreq_valid[0] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wreq_valid = '0;
        rreq_addr[1] = AW'(62);
        rreq_len[1]  = '0;
        rreq_valid[1] = 1'b1;
        #1;
        chk(rreq_ready == 3'b010, "R10", "read grant during write lock", int'(rreq_ready), 2);
        chk(wdat_ready == 3'b001, "R10", "write still locked", int'(wdat_ready), 1);
        @(posedge clk);
        @(negedge clk);
        rreq_valid = '0;
        #1;
        chk(rdat_valid == 3'b010, "R10", "read data during write lock", int'(rdat_valid), 2);
        chk(rdat_data[1] == shadow[mx(62)], "R10", "read byte during write lock",
            int'(rdat_data[1]), int'(shadow[mx(62)]));
        rdat_ready[1] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rdat_ready = '0;
        wdat_valid[0] = 1'b1;
        wdat_data[0]  = 8'hC3;
        wdat_last[0]  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wdat_valid = '0;
        wdat_last  = '0;
        shadow[mx(20)] = 8'hC3;
        wrsp_ready[0] = 1'b1;
        #1;
        chk(wrsp_valid == 3'b001, "R11", "response back to host 0", int'(wrsp_valid), 1);
        @(posedge clk);
        @(negedge clk);
        wrsp_ready = '0;
        rreq_addr[2] = AW'(20);
        rreq_len[2]  = '0;
        rreq_valid[2] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rreq_valid = '0;
        #1;
        chk(rdat_data[2] == 8'hC3, "R10", "write after concurrent read landed",
            int'(rdat_data[2]), 'hC3);
        rdat_ready[2] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rdat_ready = '0;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule